// File: doc/BRIEF.md
# Windowed Grayscale Framebuffer Raster Scanner

This block drives a 640x480 analog video raster from a framebuffer of 8-bit gray levels. A divider turns the system clock into a pixel-rate enable: four system clocks per pixel by default, so a 100 MHz clock gives the 25 MHz pixel rate of a 60 Hz display. Horizontal and vertical counters sweep the raster. The counters produce the two active-low sync pulses and the visible-area flag.

A square image window of 2^WIN_LOG2 pixels on a side sits inside the visible area. Its top-left corner is set by parameters. For each pixel inside the window, the block forms a linear address from the window-relative coordinates and presents it on a synchronous-read memory port. On the next pixel enable it latches the upper nibble of the returned gray byte onto the red, green and blue outputs together. The sync outputs are latched at the same time, so colour and sync stay aligned. Outside the window, and during blanking, all three channels are black.

The memory, any image processing and all user input are outside this block.

Top module: `gray_vga_scanner`

## Requirements
- R1: The raster counters and every output register advance only once per PIX_DIV system clocks. Between two pixel enables, all outputs and the memory address stay constant.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP pixels. `hsync_n` is low for the H_SYNC pixels that start at pixel index H_VIS+H_FP, and high for the rest of the line.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. `vsync_n` is low for the V_SYNC lines that start at line index V_VIS+V_FP, and high for the rest of the frame.
- R4: While the pixel (x, y) lies inside the window, `mem_addr` equals (y-WIN_Y0)*2^WIN_LOG2 + (x-WIN_X0). Row is in the upper half of the address and column in the lower half. The address appears in the same pixel period in which the counters reach (x, y).
- R5: While the current pixel lies outside the window or in blanking, `mem_addr` is zero.
- R6: For a window pixel, the colour outputs are updated one pixel period after its address is presented. All three channels then carry bits [7:4] of the gray byte that the memory returned for that address.
- R7: The colour outputs are zero for every pixel outside the window, including every blanking pixel.
- R8: During reset, the colour outputs are zero, both syncs are high, `mem_addr` is zero, and the raster restarts at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 2*WIN_LOG2 | Framebuffer read address |
| mem_data | input | GRAY_W | Gray byte from the framebuffer, one clock after the address |
| vga_r | output | COLOR_W | Red channel |
| vga_g | output | COLOR_W | Green channel |
| vga_b | output | COLOR_W | Blue channel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The assertions assume that the memory returns data for a stable address within one system clock. They also assume that reset is held long enough to clear the divider, and that PIX_DIV is at least two, so that data read for one pixel is settled before the next enable latches it. The bench's memory model registers its output on every clock from the address of the previous cycle, which satisfies this assumption. The bench runs a reduced raster with a window offset from the origin, so that the window edges, both porches and the frame wrap are all crossed several times within the run.

// File: rtl/gvs_pkg.sv
package gvs_pkg;

   // One registered output pixel: colour channels and active-low syncs.
   typedef struct packed {
      logic [3:0] r;
      logic [3:0] g;
      logic [3:0] b;
      logic       hs_n;
      logic       vs_n;
   } vga_px_t;

   localparam vga_px_t PX_RESET = '{r: 4'd0, g: 4'd0, b: 4'd0, hs_n: 1'b1, vs_n: 1'b1};

endpackage

// File: rtl/gvs_pixel_tick.sv
module gvs_pixel_tick #(
   parameter int PIX_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (PIX_DIV > 2) ? $clog2(PIX_DIV) : 1;
   localparam bit POW2 = (PIX_DIV & (PIX_DIV - 1)) == 0;

   initial begin
      assert (PIX_DIV >= 2) else $error("PIX_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two ratio: let the counter roll over by itself.
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign tick = &cnt;
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(PIX_DIV - 1);
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1

endmodule

// File: rtl/gvs_raster.sv
module gvs_raster #(
   parameter int H_VIS  = 640,
   parameter int H_FP   = 16,
   parameter int H_SYNC = 96,
   parameter int H_BP   = 48,
   parameter int V_VIS  = 480,
   parameter int V_FP   = 10,
   parameter int V_SYNC = 2,
   parameter int V_BP   = 33,
   parameter int XW     = 10,
   parameter int YW     = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y,
   output logic          visible,
   output logic          hs_act,
   output logic          vs_act
);
   localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
   localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
   localparam logic [XW-1:0] H_LAST = XW'(H_TOTAL - 1);
   localparam logic [YW-1:0] V_LAST = YW'(V_TOTAL - 1);
   localparam logic [XW-1:0] H_VEND = XW'(H_VIS);
   localparam logic [YW-1:0] V_VEND = YW'(V_VIS);
   localparam logic [XW-1:0] HS_BEG = XW'(H_VIS + H_FP);
   localparam logic [XW-1:0] HS_END = XW'(H_VIS + H_FP + H_SYNC);
   localparam logic [YW-1:0] VS_BEG = YW'(V_VIS + V_FP);
   localparam logic [YW-1:0] VS_END = YW'(V_VIS + V_FP + V_SYNC);

   initial begin
      assert (H_TOTAL <= (1 << XW)) else $error("XW too narrow for line length");
      assert (V_TOTAL <= (1 << YW)) else $error("YW too narrow for frame height");
      assert (H_SYNC > 0 && V_SYNC > 0) else $error("sync widths must be non-zero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x <= '0;
         y <= '0;
      end else if (tick) begin
         if (x == H_LAST) begin
            x <= '0;
            y <= (y == V_LAST) ? '0 : y + 1'b1;
         end else begin
            x <= x + 1'b1;
         end
      end
   end

   assign visible = (x < H_VEND) && (y < V_VEND);
   assign hs_act  = (x >= HS_BEG) && (x < HS_END);
   assign vs_act  = (y >= VS_BEG) && (y < VS_END);

   AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      x <= H_LAST); // R2
   AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      y <= V_LAST); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(x) && $stable(y)); // R1

endmodule

// File: rtl/gvs_window.sv
module gvs_window #(
   parameter int XW       = 10,
   parameter int YW       = 10,
   parameter int WIN_LOG2 = 8,
   parameter int WIN_X0   = 0,
   parameter int WIN_Y0   = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [XW-1:0]         x,
   input  logic [YW-1:0]         y,
   input  logic                  visible,
   output logic                  in_win,
   output logic [2*WIN_LOG2-1:0] addr
);
   localparam int WSIZE = 1 << WIN_LOG2;
   localparam logic [XW-1:0] OX = XW'(WIN_X0);
   localparam logic [YW-1:0] OY = YW'(WIN_Y0);
   localparam logic [XW-1:0] SX = XW'(WSIZE);
   localparam logic [YW-1:0] SY = YW'(WSIZE);

   initial begin
      assert (WIN_LOG2 >= 1 && WIN_LOG2 < XW && WIN_LOG2 < YW)
         else $error("window size does not fit the counters");
      assert (WIN_X0 + WSIZE < (1 << XW) && WIN_Y0 + WSIZE < (1 << YW))
         else $error("window offset too large");
   end

   // A coordinate left of or above the corner wraps to a large value,
   // so a single compare covers both edges of the window.
   logic [XW-1:0] dx;
   logic [YW-1:0] dy;
   assign dx = x - OX;
   assign dy = y - OY;

   assign in_win = visible && (dx < SX) && (dy < SY);
   assign addr   = in_win ? {dy[WIN_LOG2-1:0], dx[WIN_LOG2-1:0]} : '0;

   logic unused_hi;
   assign unused_hi = ^{dx[XW-1:WIN_LOG2], dy[YW-1:WIN_LOG2]};

   AST_WIN_INSIDE_VIS: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> visible); // R7

endmodule

// File: rtl/gray_vga_scanner.sv
module gray_vga_scanner #(
   parameter int PIX_DIV  = 4,
   parameter int H_VIS    = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BP     = 48,
   parameter int V_VIS    = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BP     = 33,
   parameter int WIN_LOG2 = 8,
   parameter int WIN_X0   = 0,
   parameter int WIN_Y0   = 0,
   parameter int GRAY_W   = 8,
   parameter int COLOR_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [2*WIN_LOG2-1:0] mem_addr,
   input  logic [GRAY_W-1:0]     mem_data,
   output logic [COLOR_W-1:0]    vga_r,
   output logic [COLOR_W-1:0]    vga_g,
   output logic [COLOR_W-1:0]    vga_b,
   output logic                  hsync_n,
   output logic                  vsync_n
);
   import gvs_pkg::*;

   localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
   localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
   localparam int XW = $clog2(H_TOTAL);
   localparam int YW = $clog2(V_TOTAL);

   initial begin
      assert (COLOR_W == 4) else $error("pixel struct carries 4-bit channels");
      assert (GRAY_W > COLOR_W) else $error("gray width must exceed colour width");
      assert (WIN_X0 + (1 << WIN_LOG2) <= H_VIS && WIN_Y0 + (1 << WIN_LOG2) <= V_VIS)
         else $error("window must lie inside the visible area");
   end

   logic          tick;
   logic [XW-1:0] x;
   logic [YW-1:0] y;
   logic          visible, hs_act, vs_act, in_win;

   gvs_pixel_tick #(.PIX_DIV(PIX_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   gvs_raster #(
      .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
      .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
      .XW(XW), .YW(YW)
   ) u_raster (
      .clk(clk), .rst_n(rst_n), .tick(tick), .x(x), .y(y),
      .visible(visible), .hs_act(hs_act), .vs_act(vs_act)
   );

   gvs_window #(
      .XW(XW), .YW(YW), .WIN_LOG2(WIN_LOG2), .WIN_X0(WIN_X0), .WIN_Y0(WIN_Y0)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .x(x), .y(y), .visible(visible),
      .in_win(in_win), .addr(mem_addr)
   );

   // Output stage: latched on the enable that ends the pixel period,
   // by which time the memory has answered the address of that period.
   logic [COLOR_W-1:0] gray_hi;
   logic               unused_lo;
   assign gray_hi   = mem_data[GRAY_W-1 -: COLOR_W];
   assign unused_lo = ^mem_data[GRAY_W-COLOR_W-1:0];

   vga_px_t px_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         px_q <= PX_RESET;
      end else if (tick) begin
         px_q.r    <= in_win ? gray_hi : '0;
         px_q.g    <= in_win ? gray_hi : '0;
         px_q.b    <= in_win ? gray_hi : '0;
         px_q.hs_n <= !hs_act;
         px_q.vs_n <= !vs_act;
      end
   end

   assign vga_r   = px_q.r;
   assign vga_g   = px_q.g;
   assign vga_b   = px_q.b;
   assign hsync_n = px_q.hs_n;
   assign vsync_n = px_q.vs_n;

   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !in_win) |=> (vga_r == '0 && vga_g == '0 && vga_b == '0)); // R7
   AST_GRAY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (vga_r == vga_g) && (vga_g == vga_b)); // R6
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(mem_addr)); // R1
   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(hsync_n) && $stable(vsync_n) && $stable(vga_r)); // R1

endmodule

// File: tb/gray_vga_scanner_test.sv
module gray_vga_scanner_test;
   localparam int PD = 4;
   localparam int HV = 40, HF = 2, HS = 4, HB = 3;
   localparam int VV = 30, VF = 1, VS = 2, VB = 2;
   localparam int WL = 3, X0 = 5, Y0 = 4;
   localparam int HT = HV + HF + HS + HB;
   localparam int VT = VV + VF + VS + VB;
   localparam int WS = 1 << WL;
   localparam int FRAME_CLK = HT * VT * PD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2*WL-1:0] mem_addr;
   logic [7:0] mem_data = 8'd0;
   logic [3:0] vga_r, vga_g, vga_b;
   logic hsync_n, vsync_n;

   always #4 clk = ~clk;

   gray_vga_scanner #(
      .PIX_DIV(PD), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
      .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
      .WIN_LOG2(WL), .WIN_X0(X0), .WIN_Y0(Y0), .GRAY_W(8), .COLOR_W(4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
      .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
      .hsync_n(hsync_n), .vsync_n(vsync_n)
   );

   function automatic logic [7:0] gray_of(int a);
      return 8'((a * 29 + (a >> 2) + 7) & 255);
   endfunction

   function automatic bit win_of(int px, int py);
      return px >= X0 && px < X0 + WS && py >= Y0 && py < Y0 + WS;
   endfunction

   function automatic int addr_of(int px, int py);
      return win_of(px, py) ? ((py - Y0) * WS + (px - X0)) : 0;
   endfunction

   // Synchronous-read framebuffer model, one clock of latency.
   always @(posedge clk) mem_data <= gray_of(int'(mem_addr));

   int total = 0, bad = 0;
   bit running = 0;

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model: its own clock count and raster position.
   int k = 0, mx = 0, my = 0;
   int e_col = 0, e_addr = 0;
   bit e_hs = 1, e_vs = 1;
   always @(posedge clk) begin
      if (!rst_n) begin
         k = 0; mx = 0; my = 0; e_col = 0; e_addr = 0; e_hs = 1; e_vs = 1;
      end else begin
         k++;
         if (k % PD == 0) begin
            e_hs  = !(mx >= HV + HF && mx < HV + HF + HS);
            e_vs  = !(my >= VV + VF && my < VV + VF + VS);
            e_col = win_of(mx, my) ? int'(gray_of(addr_of(mx, my)) >> 4) : 0;
            mx++;
            if (mx == HT) begin
               mx = 0;
               my = (my == VT - 1) ? 0 : my + 1;
            end
            e_addr = addr_of(mx, my);
         end
      end
   end

   // Per-clock comparison, sampled on the falling edge.
   int hs_low = 0, vs_gap = 0, vs_seen = 0, win_px = 0;
   bit hs_prev = 1, vs_prev = 1;
   always @(negedge clk) begin
      if (running) begin
         check(e_addr != 0 || win_of(mx, my) ? "R4 address" : "R5 address zero",
               int'(mem_addr), e_addr);
         check(e_col != 0 ? "R6 gray colour" : "R7 black", int'(vga_r), e_col);
         check("R6 green", int'(vga_g), e_col);
         check("R6 blue", int'(vga_b), e_col);
         check("R2 hsync level", int'(hsync_n), int'(e_hs));
         check("R3 vsync level", int'(vsync_n), int'(e_vs));
         if (win_of(mx, my)) win_px++;
         // R1 and R2: pulse width measured in system clocks at the port
         if (!hsync_n) hs_low++;
         if (hsync_n && !hs_prev) begin
            check("R1 R2 hsync width", hs_low, HS * PD);
            hs_low = 0;
         end
         // R3: frame period between vsync falling edges
         vs_gap++;
         if (!vsync_n && vs_prev) begin
            if (vs_seen > 0) check("R3 frame period", vs_gap, FRAME_CLK);
            vs_seen++;
            vs_gap = 0;
         end
         hs_prev = hsync_n;
         vs_prev = vsync_n;
      end
   end

   initial begin
      #(FRAME_CLK * 8 * 6);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check("R8 reset red", int'(vga_r), 0);
      check("R8 reset hsync", int'(hsync_n), 1);
      check("R8 reset vsync", int'(vsync_n), 1);
      check("R8 reset address", int'(mem_addr), 0);
      rst_n = 1'b1;
      running = 1;
      repeat (FRAME_CLK + FRAME_CLK / 2) @(negedge clk);
      // R8: mid-frame reset restarts the raster
      rst_n = 1'b0;
      running = 0;
      repeat (3) @(negedge clk);
      check("R8 reset colour again", int'(vga_g), 0);
      check("R8 reset address again", int'(mem_addr), 0);
      rst_n = 1'b1;
      hs_prev = 1; vs_prev = 1; hs_low = 0; vs_gap = 0; vs_seen = 0;
      running = 1;
      repeat (2 * FRAME_CLK + 200) @(negedge clk);
      running = 0;
      check("R4 window pixels visited", win_px > 0 ? 1 : 0, 1);
      check("R3 frames observed", vs_seen >= 2 ? 1 : 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule